// File: doc/BRIEF.md
# Latched Fault Status Collector

This block gathers fault condition lines from the rest of the chip and holds each one as a sticky flag in a single status word. Flags fall into three groups: functional errors, device errors and global warnings. Two more flags track link health. One marks that the block came out of reset. The other marks a bus framing error. Software reads the status word over a serial bus. The decoded read strobes reach this block together with a select that says whether the access targets the status word.

Two outputs feed an interrupt path. `err_o` is high while any grouped flag is set. `ec_o` is high while any grouped event has not yet been seen by a read of the status word.

The two outputs differ on persistent faults. Soft fault bits may be cleared at any time. If such a condition is still active, its flag comes back one cycle later, and `ec_o` does not rise again because no new edge occurred. Hard fault bits, such as supply and thermal-shutdown faults, are chosen by a parameter. A hard flag cannot be cleared while its condition is active. A clear-all also leaves that bit's pending change pending, while any read of the status word acknowledges it.

Top module: `diag_status_hub`

## Requirements
- R1: After reset the status word reads 10'h001 with the reset-indication flag at bit 0 set, and `err_o` and `ec_o` are low.
- R2: A rising edge on `fault_i[i]` sets status bit i+2 on the next clock. The bit stays set after the line drops, until it is cleared.
- R3: A read-and-clear with `tgt_gsr_i` high clears only the status bits whose `mask_i` bit is 1. The other bits are kept.
- R4: `clr_all_i` clears every flag, including the link flags at bits 0 (reset indication) and 1 (bus error).
- R5: A `frame_ok_i` strobe clears bits 0 and 1 and leaves the grouped flags unchanged. `bus_err_i` sets bit 1.
- R6: `err_o` is the OR of status bits N+1..2. Bits 0 and 1 affect neither `err_o` nor `ec_o`.
- R7: `ec_o` rises one cycle after a new grouped event. Any read of the status word (`rd_i` or `rc_i` with `tgt_gsr_i`) lowers it, even while the fault persists.
- R8: A soft fault that is still active when its flag is cleared sets the flag again one cycle later, and `ec_o` stays low.
- R9: A hard fault bit (HARD_MASK bit set; by default `fault_i[5:3]`, status bits 7..5) stays set through read-and-clear and clear-all while its condition is active. A clear-all does not lower `ec_o` for it, and a read does.
- R10: Read, read-and-clear and masks sent with `tgt_gsr_i` low change neither the flags nor `ec_o`.
- R11: When a new event and a clear or read for the same bit fall in the same cycle, the event wins: the flag and `ec_o` are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | NUM_FE+NUM_DE+NUM_GW | Fault condition levels: functional errors first, then device errors, then warnings |
| bus_err_i | input | 1 | Bus framing error event |
| frame_ok_i | input | 1 | Valid bus frame strobe |
| rd_i | input | 1 | Plain read strobe |
| rc_i | input | 1 | Read-and-clear strobe |
| tgt_gsr_i | input | 1 | Access targets the status word |
| mask_i | input | NUM_FE+NUM_DE+NUM_GW+2 | Clear mask for read-and-clear |
| clr_all_i | input | 1 | Clear-all command |
| status_o | output | NUM_FE+NUM_DE+NUM_GW+2 | Status word |
| err_o | output | 1 | Any grouped flag set |
| ec_o | output | 1 | Unacknowledged grouped event |

## Verification
The bench targets the corner cases where flag state and the change indication separate. A soft fault is held active across a clear: a design that re-latched by level into the change path would raise `ec_o` again, and one that never re-latched would leave `err_o` low. A hard fault is cleared while active: a design that ignored the hold would drop `err_o`, and one that let clear-all acknowledge the change would drop `ec_o`. Same-cycle event-and-clear, accesses aimed away from the status word, and link flags set with no grouped fault are also driven. These catch a clear that beats an event, a select that is ignored, and link bits wrongly ORed into the outputs.

// File: rtl/diag_status_pkg.sv
package diag_status_pkg;
  // Decoded access command, already qualified by target select.
  typedef struct packed {
    logic rd;
    logic rc;
    logic clr_all;
  } diag_cmd_t;

  localparam int unsigned LINK_BITS = 2;
  localparam int unsigned RSTIND_BIT = 0;
  localparam int unsigned BUSERR_BIT = 1;
endpackage

// File: rtl/diag_flag_cell.sv
module diag_flag_cell #(
  parameter bit HARD = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  input  logic clr_i,
  input  logic ack_i,
  input  logic ackall_i,
  output logic flag_o,
  output logic pend_o
);
  logic cond_q, flag_q, pend_q;
  logic cond_d, flag_d, pend_d;
  logic rise, hold_clr, clr_eff;

  always_comb begin
    rise     = cond_i & ~cond_q;
    hold_clr = HARD & cond_i;
    clr_eff  = clr_i & ~hold_clr;
    cond_d   = cond_i;
    // level re-sets a flag that was cleared while its condition stays active
    flag_d   = rise | (cond_i & ~flag_q) | (flag_q & ~clr_eff);
    pend_d   = rise | (pend_q & ~ack_i & ~(ackall_i & ~hold_clr));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      flag_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cond_q <= cond_d;
      flag_q <= flag_d;
      pend_q <= pend_d;
    end
  end

  assign flag_o = flag_q;
  assign pend_o = pend_q;

  // R2: a latched flag survives any cycle without a clear
  a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr_i |=> flag_q);

  // R11: a fresh edge sets flag and pending regardless of clears
  a_r11_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cond_i && !cond_q |=> flag_q && pend_q);

  generate
    if (HARD) begin : g_hard
      // R9: hard flag cannot drop while its condition is active
      a_r9_hard_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cond_i && flag_q |=> flag_q);
    end
  endgenerate
endmodule

// File: rtl/diag_flag_bank.sv
module diag_flag_bank
  import diag_status_pkg::*;
#(
  parameter int unsigned NBITS = 8,
  parameter logic [NBITS-1:0] HARD_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] cond_i,
  input  diag_cmd_t        cmd_i,
  input  logic [NBITS-1:0] mask_i,
  output logic [NBITS-1:0] flags_o,
  output logic [NBITS-1:0] pend_o
);
  logic [NBITS-1:0] clr_vec;
  logic             ack;

  always_comb begin
    clr_vec = ({NBITS{cmd_i.rc}} & mask_i) | {NBITS{cmd_i.clr_all}};
    ack     = cmd_i.rd | cmd_i.rc;
  end

  generate
    for (genvar i = 0; i < NBITS; i++) begin : g_cell
      diag_flag_cell #(.HARD(HARD_MASK[i])) u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond_i   (cond_i[i]),
        .clr_i    (clr_vec[i]),
        .ack_i    (ack),
        .ackall_i (cmd_i.clr_all),
        .flag_o   (flags_o[i]),
        .pend_o   (pend_o[i])
      );
    end
  endgenerate
endmodule

// File: rtl/diag_link_flags.sv
module diag_link_flags
  import diag_status_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_err_i,
  input  logic                 frame_ok_i,
  input  diag_cmd_t            cmd_i,
  input  logic [LINK_BITS-1:0] mask_i,
  output logic [LINK_BITS-1:0] link_o
);
  logic rstind_q, buserr_q, rstind_d, buserr_d;
  logic [LINK_BITS-1:0] clr;

  always_comb begin
    clr      = ({LINK_BITS{cmd_i.rc}} & mask_i) | {LINK_BITS{cmd_i.clr_all}};
    rstind_d = rstind_q & ~frame_ok_i & ~clr[RSTIND_BIT];
    buserr_d = bus_err_i | (buserr_q & ~frame_ok_i & ~clr[BUSERR_BIT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstind_q <= 1'b1;
      buserr_q <= 1'b0;
    end else begin
      rstind_q <= rstind_d;
      buserr_q <= buserr_d;
    end
  end

  assign link_o = {buserr_q, rstind_q};

  // R5: a valid frame with no new bus error empties both link flags
  a_r5_frame_clears: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok_i && !bus_err_i |=> !rstind_q && !buserr_q);
endmodule

// File: rtl/diag_status_hub.sv
module diag_status_hub
  import diag_status_pkg::*;
#(
  parameter int unsigned NUM_FE = 3,
  parameter int unsigned NUM_DE = 3,
  parameter int unsigned NUM_GW = 2,
  parameter logic [NUM_FE+NUM_DE+NUM_GW-1:0] HARD_MASK = 8'b0011_1000,
  localparam int unsigned NGRP = NUM_FE + NUM_DE + NUM_GW,
  localparam int unsigned SW   = NGRP + LINK_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NGRP-1:0] fault_i,
  input  logic            bus_err_i,
  input  logic            frame_ok_i,
  input  logic            rd_i,
  input  logic            rc_i,
  input  logic            tgt_gsr_i,
  input  logic [SW-1:0]   mask_i,
  input  logic            clr_all_i,
  output logic [SW-1:0]   status_o,
  output logic            err_o,
  output logic            ec_o
);
  logic            rst_s1, rst_s2;
  diag_cmd_t       cmd;
  logic [NGRP-1:0] flags, pend;
  logic [LINK_BITS-1:0] link;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  always_comb begin
    cmd.rd      = rd_i & tgt_gsr_i;
    cmd.rc      = rc_i & tgt_gsr_i;
    cmd.clr_all = clr_all_i;
  end

  diag_flag_bank #(.NBITS(NGRP), .HARD_MASK(HARD_MASK)) u_bank (
    .clk     (clk),
    .rst_n   (rst_s2),
    .cond_i  (fault_i),
    .cmd_i   (cmd),
    .mask_i  (mask_i[SW-1:LINK_BITS]),
    .flags_o (flags),
    .pend_o  (pend)
  );

  diag_link_flags u_link (
    .clk        (clk),
    .rst_n      (rst_s2),
    .bus_err_i  (bus_err_i),
    .frame_ok_i (frame_ok_i),
    .cmd_i      (cmd),
    .mask_i     (mask_i[LINK_BITS-1:0]),
    .link_o     (link)
  );

  assign status_o = {flags, link};
  assign err_o    = |flags;
  assign ec_o     = |pend;

  // R10: with no status-word target and no clear-all, grouped flags only grow
  a_r10_foreign_no_clear: assert property (@(posedge clk) disable iff (!rst_s2)
    !tgt_gsr_i && !clr_all_i |=>
      ((status_o[SW-1:LINK_BITS] & $past(status_o[SW-1:LINK_BITS]))
        == $past(status_o[SW-1:LINK_BITS])));
endmodule

// File: tb/sim_diag_status_hub.sv
module sim_diag_status_hub;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] fault_i = '0;
  logic       bus_err_i = 1'b0, frame_ok_i = 1'b0;
  logic       rd_i = 1'b0, rc_i = 1'b0, tgt_gsr_i = 1'b0, clr_all_i = 1'b0;
  logic [9:0] mask_i = '0;
  logic [9:0] status_o;
  logic       err_o, ec_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [9:0] st;
    logic       err;
    logic       ec;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  diag_status_hub u0 (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .bus_err_i(bus_err_i),
    .frame_ok_i(frame_ok_i), .rd_i(rd_i), .rc_i(rc_i), .tgt_gsr_i(tgt_gsr_i),
    .mask_i(mask_i), .clr_all_i(clr_all_i), .status_o(status_o),
    .err_o(err_o), .ec_o(ec_o)
  );

  // monitor: compare at the falling edge, between input changes
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (status_o !== e.st || err_o !== e.err || ec_o !== e.ec) begin
        errors++;
        $display("FAIL %s: got st=%h err=%b ec=%b exp st=%h err=%b ec=%b",
                 e.tag, status_o, err_o, ec_o, e.st, e.err, e.ec);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    rd_i = 0; rc_i = 0; clr_all_i = 0; frame_ok_i = 0; bus_err_i = 0;
    tgt_gsr_i = 0; mask_i = '0;
  endtask

  task automatic expect_out(logic [9:0] st, logic err, logic ec, string tag);
    exp_t e;
    e.st = st; e.err = err; e.ec = ec; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) tick();
    expect_out(10'h001, 0, 0, "R1 reset state");
    tick();

    frame_ok_i = 1; tick();
    expect_out(10'h000, 0, 0, "R5 frame clears reset flag");

    fault_i[0] = 1; tick();
    expect_out(10'h004, 1, 1, "R2 R6 R7 event latched");
    fault_i[0] = 0; tick();
    expect_out(10'h004, 1, 1, "R2 flag held after line drop");
    rd_i = 1; tgt_gsr_i = 1; tick();
    expect_out(10'h004, 1, 0, "R7 read lowers ec");
    bus_err_i = 1; tick();
    expect_out(10'h006, 1, 0, "R5 bus error sets bit1");
    frame_ok_i = 1; tick();
    expect_out(10'h004, 1, 0, "R5 frame keeps grouped flags");

    fault_i[6] = 1; tick();
    expect_out(10'h104, 1, 1, "R2 warning latched");
    fault_i[6] = 0; tick();
    rc_i = 1; tgt_gsr_i = 1; mask_i = 10'h004; tick();
    expect_out(10'h100, 1, 0, "R3 masked clear only");

    clr_all_i = 1; tick();
    expect_out(10'h000, 0, 0, "R4 clear all");
    bus_err_i = 1; tick();
    expect_out(10'h002, 0, 0, "R6 link flag no err/ec");
    clr_all_i = 1; tick();
    expect_out(10'h000, 0, 0, "R4 clear all link");

    fault_i[1] = 1; tick();
    expect_out(10'h008, 1, 1, "R2 soft fault");
    rd_i = 1; tgt_gsr_i = 1; tick();
    expect_out(10'h008, 1, 0, "R7 read while active");
    rc_i = 1; tgt_gsr_i = 1; mask_i = 10'h008; tick();
    expect_out(10'h000, 0, 0, "R8 soft cleared");
    tick();
    expect_out(10'h008, 1, 0, "R8 soft re-set without ec");
    fault_i[1] = 0; clr_all_i = 1; tick();
    expect_out(10'h000, 0, 0, "R4 cleanup");

    fault_i[3] = 1; tick();
    expect_out(10'h020, 1, 1, "R9 hard fault set");
    clr_all_i = 1; tick();
    expect_out(10'h020, 1, 1, "R9 clear-all keeps flag and ec");
    rc_i = 1; tgt_gsr_i = 1; mask_i = 10'h020; tick();
    expect_out(10'h020, 1, 0, "R9 read-clear keeps flag");
    fault_i[3] = 0; tick();
    expect_out(10'h020, 1, 0, "R9 flag latched after release");
    rc_i = 1; tgt_gsr_i = 1; mask_i = 10'h020; tick();
    expect_out(10'h000, 0, 0, "R9 clears once inactive");
    fault_i[4] = 1; tick();
    rd_i = 1; tgt_gsr_i = 1; tick();
    expect_out(10'h040, 1, 0, "R9 plain read lowers ec");
    fault_i[4] = 0; clr_all_i = 1; tick();
    expect_out(10'h000, 0, 0, "R4 cleanup hard");

    fault_i[7] = 1; tick();
    fault_i[7] = 0;
    rc_i = 1; tgt_gsr_i = 0; mask_i = 10'h3FF; tick();
    expect_out(10'h200, 1, 1, "R10 foreign read-clear ignored");
    rd_i = 1; tgt_gsr_i = 0; tick();
    expect_out(10'h200, 1, 1, "R10 foreign read ignored");
    rd_i = 1; tgt_gsr_i = 1; tick();
    expect_out(10'h200, 1, 0, "R7 status read acknowledges");
    clr_all_i = 1; tick();

    fault_i[2] = 1; clr_all_i = 1; tick();
    expect_out(10'h010, 1, 1, "R11 event beats clear-all");
    rd_i = 1; tgt_gsr_i = 1; tick();
    fault_i[0] = 1; rd_i = 1; tgt_gsr_i = 1; tick();
    expect_out(10'h014, 1, 1, "R11 event beats read");
    fault_i = '0; clr_all_i = 1; tick();
    expect_out(10'h000, 0, 0, "R4 final clear");
    bus_err_i = 1; frame_ok_i = 1; tick();
    expect_out(10'h002, 0, 0, "R11 bus error beats frame");

    tick();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule